// File: doc/BRIEF.md
# Video Access Slot Sequencer

This block produces the per-scanline slot timing of a tile-based video display processor. An 8-bit slot counter steps once for each slot-enable pulse. Within each line it jumps over a range of values that depends on the column mode, and it raises a one-cycle horizontal-interrupt marker when it reaches a mode-dependent count. Each slot the counter enters is sorted into one of three kinds: a slot open to external memory access, a memory refresh slot, or a slot held back for rendering.

The sorting depends on the column mode (32 or 40 columns) and on whether the display is active or blanked. During active display only a short fixed list of counts per mode is open to external access. During blanking every count that is not a refresh count is open. The block counts the access slots of each line from the interrupt point, so that a downstream transfer engine can convert slot numbers into time. A small helper holds off service of a write that lands in an empty write FIFO for a fixed number of slots.

The mode and display-active inputs are taken only when the counter reaches the interrupt point. A line therefore always runs under a single mode.

Top module: `vid_slot_seq`

## Requirements
- R1: `slotCount` is 8 bits wide. It advances by one count on each clock edge that samples `slotEn` high, holds when `slotEn` is low, and wraps from 0xFF to 0x00. All outputs are registered and change in the cycle after the sampled pulse.
- R2: In 40-column mode (`wide40`=1) the counter moves from 0xB6 directly to 0xE5, which gives 210 slots per line.
- R3: In 32-column mode (`wide40`=0) the counter moves from 0x93 directly to 0xE9, which gives 171 slots per line.
- R4: `hintMark` is a one-cycle pulse in the cycle in which `slotCount` has just become the interrupt count: 0x84 in 32-column mode, 0xA4 in 40-column mode.
- R5: In active 32-column display, `accessStb` pulses only on counts 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 129, 130, 145 and 243. That is 16 per line.
- R6: In active 40-column display, `accessStb` pulses only on counts 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 130, 138, 146, 161, 162 and 232. That is 18 per line.
- R7: `refreshStb` pulses on counts 26, 58, 90, 122 and 250 in both modes, and also on 154 in 40-column mode. This holds whether the display is active or blanked. `accessStb` and `refreshStb` are never high together.
- R8: In blanked display (`dispActive`=0), every slot that is not a refresh slot pulses `accessStb`. That gives 166 access slots per line in 32-column mode and 204 in 40-column mode.
- R9: While `accessStb` is high, `accessIdx` gives its 0-based position among the access slots since the most recent interrupt point, counting the interrupt slot itself. `accessIdx` holds its value between strobes.
- R10: `wide40` and `dispActive` are sampled only on the step that enters the interrupt count of the mode in force. A change in the middle of a line has no effect on the gap, the classification or the interrupt count until that step.
- R11: A synchronous active-high `rst` loads `slotCount` with the interrupt count of the mode selected by `wide40`. It clears `hintMark`, `accessStb`, `refreshStb` and `accessIdx`, and leaves `fifoReady` high.
- R12: A `wrStart` pulse drops `fifoReady` in the next cycle. `fifoReady` stays low until three `slotEn` pulses have been sampled after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotEn | input | 1 | Slot-enable pulse; one slot per sampled high |
| wide40 | input | 1 | 1 = 40-column mode, 0 = 32-column mode |
| dispActive | input | 1 | 1 = active display, 0 = blanked |
| wrStart | input | 1 | A write entered an empty write FIFO |
| slotCount | output | 8 | Current slot counter value |
| hintMark | output | 1 | Horizontal-interrupt point reached |
| accessStb | output | 1 | Current slot is an external access slot |
| refreshStb | output | 1 | Current slot is a refresh slot |
| accessIdx | output | 8 | Ordinal of the current access slot within the line |
| fifoReady | output | 1 | FIFO start latency has elapsed |

## Verification
The embedded assertions check the following on every cycle:
- the counter holds when no slot pulse arrived;
- the interrupt marker coincides with one of the two interrupt counts;
- access and refresh never coincide;
- an access on the interrupt slot carries index zero;
- a FIFO start always drops the ready flag.

Only the bench's scenarios can show the rest:
- the exact per-mode access lists and per-line totals (16, 18, 166, 204);
- the line lengths of 171 and 210 slots;
- the deferral of a mid-line mode change to the next interrupt point;
- the exact three-slot latency.

// File: rtl/vss_pkg.sv
package vss_pkg;

  localparam int CNT_W = 8;
  localparam int IDX_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [IDX_W-1:0] idx_t;

  // strobes handed from control to datapath on every slot step
  typedef struct packed {
    logic step;     // a slot pulse was taken this cycle
    logic hintHit;  // the step enters the interrupt count
    cnt_t nxt;      // count being entered
    logic wide;     // column mode that governs the entered slot
    logic act;      // display-active flag that governs the entered slot
  } slot_step_t;

  function automatic cnt_t hintOf(input logic wide);
    return wide ? cnt_t'(8'hA4) : cnt_t'(8'h84);
  endfunction

  function automatic cnt_t gapLast(input logic wide);
    return wide ? cnt_t'(8'hB6) : cnt_t'(8'h93);
  endfunction

  function automatic cnt_t gapResume(input logic wide);
    return wide ? cnt_t'(8'hE5) : cnt_t'(8'hE9);
  endfunction

  function automatic logic isRefresh(input cnt_t n, input logic wide);
    case (n)
      cnt_t'(26), cnt_t'(58), cnt_t'(90), cnt_t'(122), cnt_t'(250): return 1'b1;
      cnt_t'(154): return wide;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isListed(input cnt_t n, input logic wide);
    logic common;
    case (n)
      cnt_t'(2), cnt_t'(10), cnt_t'(18), cnt_t'(34), cnt_t'(42), cnt_t'(50),
      cnt_t'(66), cnt_t'(74), cnt_t'(82), cnt_t'(98), cnt_t'(106),
      cnt_t'(114), cnt_t'(130): common = 1'b1;
      default: common = 1'b0;
    endcase
    if (wide) begin
      case (n)
        cnt_t'(138), cnt_t'(146), cnt_t'(161), cnt_t'(162), cnt_t'(232): return 1'b1;
        default: return common;
      endcase
    end else begin
      case (n)
        cnt_t'(129), cnt_t'(145), cnt_t'(243): return 1'b1;
        default: return common;
      endcase
    end
  endfunction

  function automatic logic isAccess(input cnt_t n, input logic wide, input logic act);
    return act ? isListed(n, wide) : !isRefresh(n, wide);
  endfunction

endpackage

// File: rtl/vss_ctrl.sv
module vss_ctrl
  import vss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       slotEn,
  input  logic       wide40,
  input  logic       dispActive,
  output cnt_t       count,
  output slot_step_t stepInfo
);

  logic modeWide, modeAct;
  cnt_t nxtRaw;
  logic hitHint;

  always_comb begin
    nxtRaw  = (count == gapLast(modeWide)) ? gapResume(modeWide) : count + cnt_t'(1);
    hitHint = (nxtRaw == hintOf(modeWide));
    stepInfo.step    = slotEn;
    stepInfo.hintHit = slotEn && hitHint;
    stepInfo.nxt     = nxtRaw;
    stepInfo.wide    = hitHint ? wide40     : modeWide;
    stepInfo.act     = hitHint ? dispActive : modeAct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= hintOf(wide40);
      modeWide <= wide40;
      modeAct  <= dispActive;
    end else if (slotEn) begin
      count <= nxtRaw;
      if (hitHint) begin
        modeWide <= wide40;
        modeAct  <= dispActive;
      end
    end
  end

  // R1
  hold_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(slotEn) && !$past(rst)) |-> $stable(count));

  // R4
  hint_count_chk: assert property (@(posedge clk) disable iff (rst)
    stepInfo.hintHit |=> (count == 8'h84 || count == 8'hA4));

endmodule

// File: rtl/vss_class.sv
module vss_class
  import vss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slot_step_t stepInfo,
  output logic       accessStb,
  output logic       refreshStb,
  output logic       hintMark,
  output idx_t       accessIdx
);

  idx_t idxNext;
  idx_t base;
  logic accNow, refNow;

  always_comb begin
    base   = stepInfo.hintHit ? '0 : idxNext;
    accNow = isAccess(stepInfo.nxt, stepInfo.wide, stepInfo.act);
    refNow = isRefresh(stepInfo.nxt, stepInfo.wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accessStb  <= 1'b0;
      refreshStb <= 1'b0;
      hintMark   <= 1'b0;
      accessIdx  <= '0;
      idxNext    <= '0;
    end else begin
      accessStb  <= stepInfo.step && accNow;
      refreshStb <= stepInfo.step && refNow;
      hintMark   <= stepInfo.hintHit;
      if (stepInfo.step) begin
        if (accNow) begin
          accessIdx <= base;
          idxNext   <= base + idx_t'(1);
        end else begin
          idxNext <= base;
        end
      end
    end
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(accessStb && refreshStb));

  // R9
  idx_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (hintMark && accessStb) |-> (accessIdx == '0));

endmodule

// File: rtl/vss_fifo_lat.sv
module vss_fifo_lat #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic slotEn,
  input  logic wrStart,
  output logic fifoReady
);

  localparam int LW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic [LW-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (rst)                            latCnt <= '0;
    else if (wrStart)                   latCnt <= LW'(LAT);
    else if (slotEn && latCnt != '0)    latCnt <= latCnt - LW'(1);
  end

  assign fifoReady = (latCnt == '0);

  // R12
  start_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    wrStart |=> !fifoReady);

endmodule

// File: rtl/vid_slot_seq.sv
module vid_slot_seq
  import vss_pkg::*;
#(
  parameter int FIFO_LAT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slotEn,
  input  logic       wide40,
  input  logic       dispActive,
  input  logic       wrStart,
  output logic [7:0] slotCount,
  output logic       hintMark,
  output logic       accessStb,
  output logic       refreshStb,
  output logic [7:0] accessIdx,
  output logic       fifoReady
);

  slot_step_t stepInfo;
  cnt_t       count;
  idx_t       idx;

  vss_ctrl uCtrl (
    .clk(clk), .rst(rst), .slotEn(slotEn), .wide40(wide40),
    .dispActive(dispActive), .count(count), .stepInfo(stepInfo)
  );

  vss_class uClass (
    .clk(clk), .rst(rst), .stepInfo(stepInfo), .accessStb(accessStb),
    .refreshStb(refreshStb), .hintMark(hintMark), .accessIdx(idx)
  );

  vss_fifo_lat #(.LAT(FIFO_LAT)) uFifo (
    .clk(clk), .rst(rst), .slotEn(slotEn), .wrStart(wrStart),
    .fifoReady(fifoReady)
  );

  assign slotCount = count;
  assign accessIdx = idx;

endmodule

// File: tb/sim_vid_slot_seq.sv
module sim_vid_slot_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slotEn = 1'b0;
  logic       wide40 = 1'b0;
  logic       dispActive = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] slotCount;
  logic       hintMark, accessStb, refreshStb, fifoReady;
  logic [7:0] accessIdx;

  vid_slot_seq u0 (
    .clk(clk), .rst(rst), .slotEn(slotEn), .wide40(wide40),
    .dispActive(dispActive), .wrStart(wrStart), .slotCount(slotCount),
    .hintMark(hintMark), .accessStb(accessStb), .refreshStb(refreshStb),
    .accessIdx(accessIdx), .fifoReady(fifoReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  int enPat = 1;   // 0 every cycle, 1 two of three, 2 none
  bit armed = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int list32[16] = '{145, 243, 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 129, 130};
  int list40[18] = '{232, 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 130, 138, 146, 161, 162};
  int ref32[$] = '{250, 26, 58, 90, 122};

  function automatic bit inList(int v, bit w);
    if (w) begin foreach (list40[i]) if (list40[i] == v) return 1; end
    else   begin foreach (list32[i]) if (list32[i] == v) return 1; end
    return 0;
  endfunction

  function automatic bit isRef(int v, bit w);
    foreach (ref32[i]) if (ref32[i] == v) return 1;
    return w && v == 154;
  endfunction

  function automatic int hintCnt(bit w);
    return w ? 164 : 132;
  endfunction

  int mCount, mIdxNext, eIdx, mLat;
  bit mWide, mAct, eAcc, eRef, eHint;

  always @(posedge clk) begin
    if (rst) begin
      mWide = wide40; mAct = dispActive; mCount = hintCnt(wide40);
      eAcc = 0; eRef = 0; eHint = 0; eIdx = 0; mIdxNext = 0; mLat = 0;
    end else begin
      int n, base;
      bit acc;
      eAcc = 0; eRef = 0; eHint = 0;
      if (slotEn) begin
        if (!mWide && mCount == 147)     n = 233;
        else if (mWide && mCount == 182) n = 229;
        else                             n = (mCount + 1) % 256;
        base = mIdxNext;
        if (n == hintCnt(mWide)) begin
          mWide = wide40; mAct = dispActive; eHint = 1; base = 0;
        end
        acc = mAct ? inList(n, mWide) : !isRef(n, mWide);
        eRef = isRef(n, mWide);
        eAcc = acc;
        if (acc) begin eIdx = base; mIdxNext = base + 1; end
        else mIdxNext = base;
        mCount = n;
      end
      if (wrStart) mLat = 3;
      else if (slotEn && mLat > 0) mLat = mLat - 1;
    end
    armed = 1;
  end

  // ---------------- per-line statistics ----------------
  int lineAcc = 0, lineRef = 0, lineSlots = 0, prevCount = -1;
  int lastAcc = 0, lastRef = 0, lastSlots = 0, nHint = 0, lastHintCount = 0;

  always @(negedge clk) begin
    if (armed) begin
      chk("R1 R2 R3 count", slotCount, mCount);
      chk("R4 hint", hintMark, eHint);
      chk("R5 R6 R8 access", accessStb, eAcc);
      chk("R7 refresh", refreshStb, eRef);
      chk("R9 index", accessIdx, eIdx);
      chk("R12 fifo", fifoReady, (mLat == 0));
    end
    if (!rst) begin
      if (hintMark) begin
        lastAcc = lineAcc; lastRef = lineRef; lastSlots = lineSlots;
        lastHintCount = slotCount; nHint++;
        lineAcc = accessStb; lineRef = refreshStb; lineSlots = 1;
      end else begin
        lineAcc += accessStb; lineRef += refreshStb;
        if (slotCount != prevCount) lineSlots++;
      end
      prevCount = slotCount;
    end
    cyc++;
    case (enPat)
      0: slotEn <= 1'b1;
      1: slotEn <= (cyc % 3 != 0);
      default: slotEn <= 1'b0;
    endcase
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic waitHints(input int k);
    int target = nHint + k;
    wait (nHint >= target);
  endtask

  task automatic runMode(input bit w, input bit a, input int expAcc,
                         input int expSlots, input int expRef, input string tag);
    @(negedge clk);
    wide40 = w; dispActive = a;
    waitHints(3);
    chk({tag, " access per line"}, lastAcc, expAcc);
    chk({(w ? "R2" : "R3"), " slots per line"}, lastSlots, expSlots);
    chk("R7 refresh per line", lastRef, expRef);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset count", slotCount, 8'h84);
    chk("R11 reset access", accessStb, 0);
    chk("R11 reset refresh", refreshStb, 0);
    chk("R11 reset hint", hintMark, 0);
    chk("R11 reset index", accessIdx, 0);
    chk("R11 reset ready", fifoReady, 1);
    rst = 1'b0;

    runMode(0, 0, 166, 171, 5, "R8");
    runMode(1, 0, 204, 210, 6, "R8");
    runMode(1, 1, 18, 210, 6, "R6");
    runMode(0, 1, 16, 171, 5, "R5");

    // R10: mid-line change defers to the next interrupt point
    @(negedge clk); wide40 = 0; dispActive = 0;
    waitHints(2);
    wait (slotCount == 8'h10);
    @(negedge clk); wide40 = 1; dispActive = 1;
    waitHints(1);
    chk("R10 old interrupt count", lastHintCount, 8'h84);
    chk("R10 old-mode line total", lastAcc, 166);
    waitHints(1);
    chk("R10 new interrupt count", lastHintCount, 8'hA4);

    // R12: start latency, with stalls in between
    @(negedge clk); wrStart = 1;
    @(negedge clk); wrStart = 0;
    chk("R12 ready dropped", fifoReady, 0);
    enPat = 2;
    repeat (20) @(negedge clk);
    chk("R12 no slots no release", fifoReady, 0);
    chk("R1 hold while idle", accessStb | refreshStb | hintMark, 0);
    enPat = 0;
    repeat (6) @(negedge clk);
    chk("R12 released", fifoReady, 1);

    // every-cycle slot pulses, blanked 40-column
    runMode(1, 0, 204, 210, 6, "R8");

    // reset in the middle of a line with 40-column selected
    @(negedge clk); rst = 1; wide40 = 1;
    @(negedge clk);
    chk("R11 reset count 40", slotCount, 8'hA4);
    chk("R11 reset access 40", accessStb, 0);
    rst = 0;
    repeat (300) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule